// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Band Delay

This block produces a pair of complementary, active-high drive signals for a half-bridge power stage. A free-running timer advances once per clock-enable tick, where one tick stands for one instruction cycle. It counts from zero up to a programmed period value and then restarts. The main output is asserted while the timer is below the duty value. The complementary output is asserted from the duty match until the end of the period.

Each output must wait a programmable dead-band delay before it turns on. The delay is a 7-bit count of ticks, measured from that output's turn-on point. This keeps one power switch from turning on before the other has had time to turn off. If an output's active window is no longer than the delay, that output stays low for the whole period.

Period, duty and dead-band inputs are captured into shadow registers only when a new period starts. The host can therefore change them at any time without disturbing the period already in progress. Clearing the enable forces both outputs low and holds the timer at zero.

Top module: `cdpwm_deadband`

## Requirements
- R1: After reset both outputs are low. The first enabled period starts with the timer at zero.
- R2: While enabled, the timer advances by one on each tick. When it equals the captured period value P, the next tick returns it to zero, so a period lasts P+1 ticks.
- R3: The main output may be high only while the timer is below the captured duty value D. It turns high once the timer has reached at least the captured dead-band value.
- R4: The complementary output may be high only while the timer is at or above D. It turns high once at least the dead-band number of ticks have passed since the timer reached D.
- R5: The dead-band value is 7 bits wide (0 to 127). Its counters advance only on ticks, and each counter restarts at the turn-on point of its own output.
- R6: An output whose dead-band value is equal to or larger than the length of its window stays low for the entire period. This includes a delay of 127 ticks.
- R7: The two outputs are never high in the same clock cycle, including while enable toggles or inputs change.
- R8: Period, duty and dead-band input values take effect only when a new period starts, or immediately while the block is disabled.
- R9: While enable is low both outputs are low one clock later, and the timer is held at zero.
- R10: When no tick arrives, the timer and the dead-band counters hold their values.
- R11: Both outputs are registered. They reflect the state from the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces outputs low and timer to zero |
| tick | input | 1 | Clock enable, one pulse per instruction cycle |
| period_i | input | CNT_W | Period value (timer terminal count) |
| duty_i | input | CNT_W | Duty value (main-output turn-off point) |
| dead_i | input | DB_W | Dead-band delay in ticks |
| drv_main_o | output | 1 | Main drive output, active-high |
| drv_comp_o | output | 1 | Complementary drive output, active-high |

## Verification
The period wrap and the start of a dead-band count can happen in the same cycle. With the duty value at zero, the tick that wraps the timer also captures new shadow values and restarts the complementary output's dead-band counter. The bench provokes this by changing period, duty and dead-band values in the middle of a period, by setting the duty to zero, and by dropping enable close to a wrap. A behavioural reference model, stepped once per clock, judges every cycle of both outputs and also checks that the two outputs never overlap.

// File: rtl/cdpwm_pkg.sv
package cdpwm_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic [0:0] {
    CH_MAIN = 1'b0,
    CH_COMP = 1'b1
  } pwm_ch_e;
endpackage

// File: rtl/cdpwm_timebase.sv
module cdpwm_timebase #(
  parameter int CNT_W = 8,
  parameter int DB_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DB_W-1:0]  dead_i,
  output logic [CNT_W-1:0] timer_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [DB_W-1:0]  dead_o,
  output logic [CNT_W-1:0] timer_nxt_o,
  output logic [CNT_W-1:0] duty_nxt_o,
  output logic             step_o
);
  logic [CNT_W-1:0] timer_q, per_q, duty_q;
  logic [DB_W-1:0]  dead_q;
  logic             wrap;

  assign wrap        = (timer_q == per_q);
  assign step_o      = en & tick;
  assign timer_nxt_o = wrap ? '0 : timer_q + 1'b1;
  assign duty_nxt_o  = wrap ? duty_i : duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q <= '0;
      per_q   <= '0;
      duty_q  <= '0;
      dead_q  <= '0;
    end else if (!en) begin
      timer_q <= '0;
      per_q   <= period_i;
      duty_q  <= duty_i;
      dead_q  <= dead_i;
    end else if (tick) begin
      timer_q <= timer_nxt_o;
      if (wrap) begin
        per_q  <= period_i;
        duty_q <= duty_i;
        dead_q <= dead_i;
      end
    end
  end

  assign timer_o = timer_q;
  assign duty_o  = duty_q;
  assign dead_o  = dead_q;

  // R2: the timer never passes the captured period
  a_r2_timer_bound: assert property (@(posedge clk) disable iff (rst)
    timer_q <= per_q);
  // R8: shadow period only changes at a wrap or while disabled
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !(tick && wrap)) |=> $stable(per_q) && $stable(duty_q) && $stable(dead_q));
  // R10: no tick, no timer movement
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(timer_q));
endmodule

// File: rtl/cdpwm_gate.sv
module cdpwm_gate #(
  parameter int DB_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            step,
  input  logic            restart,
  input  logic            in_window,
  input  logic [DB_W-1:0] dead,
  output logic            open_o
);
  logic [DB_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (step) begin
      if (restart)
        cnt_q <= '0;
      else if (cnt_q != '1)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign open_o = in_window && (cnt_q >= dead);

  // R5: a turn-on point reloads the delay count
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (step && restart) |=> (cnt_q == '0));
  // R10: the count holds without a tick
  a_r10_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/cdpwm_deadband.sv
module cdpwm_deadband #(
  parameter int CNT_W = 8,
  parameter int DB_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DB_W-1:0]  dead_i,
  output logic             drv_main_o,
  output logic             drv_comp_o
);
  import cdpwm_pkg::*;

  logic [CNT_W-1:0]  timer, duty_s, timer_nxt, duty_nxt;
  logic [DB_W-1:0]   dead_s;
  logic              step;
  logic [NUM_CH-1:0] restart, window, open;
  logic              main_q, comp_q;

  cdpwm_timebase #(.CNT_W(CNT_W), .DB_W(DB_W)) u_tb (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .period_i(period_i), .duty_i(duty_i), .dead_i(dead_i),
    .timer_o(timer), .duty_o(duty_s), .dead_o(dead_s),
    .timer_nxt_o(timer_nxt), .duty_nxt_o(duty_nxt), .step_o(step)
  );

  assign window[CH_MAIN]  = (timer < duty_s);
  assign window[CH_COMP]  = (timer >= duty_s);
  assign restart[CH_MAIN] = (timer_nxt == '0);
  assign restart[CH_COMP] = (timer_nxt == duty_nxt);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    cdpwm_gate #(.DB_W(DB_W)) u_gate (
      .clk(clk), .rst(rst), .en(en), .step(step),
      .restart(restart[ch]), .in_window(window[ch]),
      .dead(dead_s), .open_o(open[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= 1'b0;
      comp_q <= 1'b0;
    end else begin
      main_q <= en & open[CH_MAIN];
      comp_q <= en & open[CH_COMP];
    end
  end

  assign drv_main_o = main_q;
  assign drv_comp_o = comp_q;

  // R7: no shoot-through
  a_r7_never_both: assert property (@(posedge clk) disable iff (rst)
    !(main_q && comp_q));
  // R9: disable forces both outputs low
  a_r9_off_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!main_q && !comp_q));
  // R3: main output rises only after the dead-band has elapsed from period start
  a_r3_rise_after_dead: assert property (@(posedge clk) disable iff (rst)
    $rose(main_q) |-> ($past(timer) >= CNT_W'($past(dead_s))));
  // R4: complement rises only inside its window
  a_r4_comp_window: assert property (@(posedge clk) disable iff (rst)
    $rose(comp_q) |-> ($past(timer) >= $past(duty_s)));
endmodule

// File: tb/test_cdpwm_deadband.sv
module test_cdpwm_deadband;
  localparam int CW = 8;
  localparam int DW = 7;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst, en, tick;
  logic [CW-1:0] period_i, duty_i;
  logic [DW-1:0] dead_i;
  logic drv_main, drv_comp;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_div = 1;
  int m_t, m_ps, m_ds, m_db, m_ca, m_cb;

  always #2 clk = ~clk;

  cdpwm_deadband #(.CNT_W(CW), .DB_W(DW)) i_cdpwm_deadband (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .period_i(period_i), .duty_i(duty_i), .dead_i(dead_i),
    .drv_main_o(drv_main), .drv_comp_o(drv_comp)
  );

  task automatic step(input string tag);
    bit eh, el, wrap;
    int tn, nds;
    tick = (cyc % tick_div == 0);
    cyc++;
    eh = !rst && en && (m_t < m_ds) && (m_ca >= m_db);
    el = !rst && en && (m_t >= m_ds) && (m_cb >= m_db);
    if (rst) begin
      m_t = 0; m_ps = 0; m_ds = 0; m_db = 0; m_ca = 0; m_cb = 0;
    end else if (!en) begin
      m_t = 0; m_ca = 0; m_cb = 0;
      m_ps = period_i; m_ds = duty_i; m_db = dead_i;
    end else if (tick) begin
      wrap = (m_t == m_ps);
      tn   = wrap ? 0 : m_t + 1;
      nds  = wrap ? int'(duty_i) : m_ds;
      m_ca = (tn == 0)   ? 0 : ((m_ca < DMAX) ? m_ca + 1 : DMAX);
      m_cb = (tn == nds) ? 0 : ((m_cb < DMAX) ? m_cb + 1 : DMAX);
      if (wrap) begin
        m_ps = period_i; m_ds = duty_i; m_db = dead_i;
      end
      m_t = tn;
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (drv_main !== eh || drv_comp !== el) begin
      errors++;
      $display("FAIL %s main/comp actual %b%b expected %b%b at cycle %0d",
               tag, drv_main, drv_comp, eh, el, cyc);
    end
    checks++;
    if (drv_main === 1'b1 && drv_comp === 1'b1) begin
      errors++;
      $display("FAIL R7 overlap actual 11 expected not 11 at cycle %0d", cyc);
    end
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic setv(input int p, input int d, input int db);
    period_i = CW'(p); duty_i = CW'(d); dead_i = DW'(db);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; tick = 1'b1;
    setv(9, 4, 0);
    run("R1 reset", 3);
    rst = 1'b0;
    run("R1 idle", 2);
    en = 1'b1;
    run("R2 R3 R4 R11 no dead-band", 30);
    setv(9, 4, 2);
    run("R5 dead-band 2", 30);
    setv(9, 4, 5);
    run("R6 main window shorter than delay", 30);
    setv(5, 2, 1);
    run("R8 mid-period update", 7);
    run("R8 after update", 20);
    tick_div = 3;
    run("R10 sparse ticks", 60);
    tick_div = 1;
    setv(6, 0, 1);
    run("R4 duty zero wrap restart", 25);
    setv(6, 9, 0);
    run("R3 duty above period", 20);
    setv(7, 3, 1);
    run("R9 before toggle", 10);
    en = 1'b0;
    run("R9 disabled", 4);
    en = 1'b1;
    run("R9 re-enable", 6);
    en = 1'b0;
    run("R9 drop near wrap", 1);
    en = 1'b1;
    run("R7 enable toggling", 12);
    setv(140, 130, 127);
    run("R6 R5 max delay", 300);
    setv(20, 10, 0);
    run("R7 settle", 25);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule